// File: doc/BRIEF.md
# Write-Only Two-Wire Configuration Receiver

This block is the target side of a two-wire serial bus (clock and data lines) that a host uses to program a bank of device control registers. It samples both lines with the system clock, finds START and STOP conditions, shifts in bytes most significant bit first and acknowledges each byte it accepts by pulling the data line low. It never drives data back to the host.

A frame opens with a fixed address byte whose low bit is the write bit. Two placeholder bytes follow: a command byte and a byte count. Their values are ignored, but they still occupy positions in the frame. The data bytes come next. Only the first few data bytes reach the register bank. The rest, including anything past the nominal end of the frame, are acknowledged and dropped. Every register powers up at a default value, so the bus is optional. Bits marked reserved keep their default no matter what is written.

The first register byte is decoded into an operating mode and a frequency-select source. A second field is a frequency code, and the source bit chooses whether that code comes from the strap inputs or from the register. The full register bank is also brought out, so the output-enable bits in the later bytes can be used directly.

Top module: `cfgbus_rx`

## Requirements
- R1: After reset, `regs_o` equals 48'h33_00_3F_7F_0F_00 (register byte k at bits 8k+7..8k), `mode_o` is 0, `freq_src_o` is 0 and `sda_pull_o` is 0.
- R2: The address byte 8'hD2 is acknowledged. Any other address byte is not acknowledged, nor is any later byte of that frame, and no register changes.
- R3: Each byte is taken most significant bit first: the first data bit of a byte after START or after an acknowledge is bit 7.
- R4: Frame positions 1 and 2 (command and count) are acknowledged and never written to a register. Data byte 0 is the fourth byte of the frame.
- R5: Data bytes 0 to 5 are written to register bytes 0 to 5. Data bytes 6 and 7, and any byte after them, are acknowledged and change no register.
- R6: After a matching address, every complete byte is acknowledged by `sda_pull_o` being high from after the eighth clock falls until the ninth clock falls.
- R7: `mode_o` equals register byte 0 bits 1:0 (00 normal, 01 bypass test, 10 spread on, 11 outputs off).
- R8: Register byte 0 bit 3 picks the frequency code source. When it is 0, `freq_code_o` follows `strap_fs_i`. When it is 1, `freq_code_o` is {byte0[2], byte0[6:4]}. `freq_src_o` shows that bit.
- R9: A STOP or a repeated START in the middle of a frame ends that frame. Register bytes already completed stay written and the byte being shifted is dropped. A repeated START begins a new frame at the address byte.
- R10: Register bits outside the write mask 48'h33_00_3F_7F_0F_7F keep their reset value whatever is written.
- R11: `regs_o` bit 8k+b is register byte k bit b for every byte k.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock, much faster than the bus clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| scl_i | input | 1 | Bus clock line as seen at the pin |
| sda_i | input | 1 | Bus data line as seen at the pin (wired-AND level) |
| strap_fs_i | input | 4 | Frequency code latched from strap pins |
| sda_pull_o | output | 1 | High to pull the data line low (acknowledge) |
| mode_o | output | 2 | Operating mode field |
| freq_src_o | output | 1 | 1 when the frequency code comes from the register |
| freq_code_o | output | 4 | Selected frequency code |
| regs_o | output | 48 | Whole register bank, byte k at bits 8k+7..8k |

## Verification
The bench builds the block with its default parameters: address 8'hD2, three header bytes, eight data bytes, six register bytes and two synchronizer stages. It drives the bus with a quarter bit period of ten system clocks. This frame length lets single runs reach the discarded tail bytes and bytes past the frame end. The six-byte bank with its mixed write mask brings reserved bits into reach in several bytes at once. The short quarter period puts each acknowledge only a few cycles ahead of the next clock rise, which tests the synchronizer latency margin.

// File: rtl/cfgbus_pkg.sv
package cfgbus_pkg;
  typedef enum logic [1:0] {
    ST_IDLE = 2'd0,
    ST_RX   = 2'd1,
    ST_ACK  = 2'd2,
    ST_SKIP = 2'd3
  } rx_state_e;

  localparam int BITS_PER_BYTE = 8;
endpackage

// File: rtl/cfgbus_sync.sv
module cfgbus_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic scl_i,
  input  logic sda_i,
  output logic sda_bit_o,
  output logic scl_rise_o,
  output logic scl_fall_o,
  output logic start_o,
  output logic stop_o
);
  logic [STAGES-1:0] scl_ff, sda_ff;
  logic              scl_prev, sda_prev;
  logic              scl_s, sda_s;

  assign scl_s = scl_ff[STAGES-1];
  assign sda_s = sda_ff[STAGES-1];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      scl_ff   <= '1;
      sda_ff   <= '1;
      scl_prev <= 1'b1;
      sda_prev <= 1'b1;
    end else begin
      scl_ff   <= {scl_ff[STAGES-2:0], scl_i};
      sda_ff   <= {sda_ff[STAGES-2:0], sda_i};
      scl_prev <= scl_s;
      sda_prev <= sda_s;
    end
  end

  assign sda_bit_o  = sda_s;
  assign scl_rise_o = scl_s & ~scl_prev;
  assign scl_fall_o = ~scl_s & scl_prev;
  assign start_o    = scl_s & scl_prev & sda_prev & ~sda_s;
  assign stop_o     = scl_s & scl_prev & ~sda_prev & sda_s;
endmodule

// File: rtl/cfgbus_engine.sv
module cfgbus_engine
  import cfgbus_pkg::*;
#(
  parameter logic [7:0] ADDR_BYTE  = 8'hD2,
  parameter int         HDR_BYTES  = 3,
  parameter int         DATA_BYTES = 8,
  parameter int         REG_BYTES  = 6,
  localparam int        FRAME_BYTES = HDR_BYTES + DATA_BYTES,
  localparam int        IDX_W       = $clog2(FRAME_BYTES + 1),
  localparam int        RIDX_W      = (REG_BYTES > 1) ? $clog2(REG_BYTES) : 1
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              sda_bit_i,
  input  logic              scl_rise_i,
  input  logic              scl_fall_i,
  input  logic              start_i,
  input  logic              stop_i,
  output logic              sda_pull_o,
  output logic              wr_en_o,
  output logic [RIDX_W-1:0] wr_idx_o,
  output logic [7:0]        wr_data_o
);
  rx_state_e        state_q, state_d;
  logic [3:0]       bit_cnt_q, bit_cnt_d;
  logic [IDX_W-1:0] byte_idx_q, byte_idx_d;
  logic [7:0]       shreg_q, shreg_d;
  logic             pull_q, pull_d;
  logic             in_window;

  assign in_window = (byte_idx_q >= IDX_W'(HDR_BYTES)) &&
                     (byte_idx_q <  IDX_W'(HDR_BYTES + REG_BYTES));

  always_comb begin
    state_d    = state_q;
    bit_cnt_d  = bit_cnt_q;
    byte_idx_d = byte_idx_q;
    shreg_d    = shreg_q;
    pull_d     = pull_q;
    wr_en_o    = 1'b0;
    if (stop_i) begin
      state_d = ST_IDLE;
      pull_d  = 1'b0;
    end else if (start_i) begin
      state_d    = ST_RX;
      bit_cnt_d  = '0;
      byte_idx_d = '0;
      pull_d     = 1'b0;
    end else begin
      case (state_q)
        ST_RX: begin
          if (scl_rise_i && bit_cnt_q < 4'(BITS_PER_BYTE)) begin
            shreg_d   = {shreg_q[6:0], sda_bit_i};
            bit_cnt_d = bit_cnt_q + 4'd1;
          end
          if (scl_fall_i && bit_cnt_q == 4'(BITS_PER_BYTE)) begin
            if (byte_idx_q == '0 && shreg_q != ADDR_BYTE) begin
              state_d = ST_SKIP;
            end else begin
              state_d = ST_ACK;
              pull_d  = 1'b1;
              wr_en_o = in_window;
            end
          end
        end
        ST_ACK: begin
          if (scl_fall_i) begin
            state_d   = ST_RX;
            pull_d    = 1'b0;
            bit_cnt_d = '0;
            if (byte_idx_q != IDX_W'(FRAME_BYTES))
              byte_idx_d = byte_idx_q + IDX_W'(1);
          end
        end
        default: ;
      endcase
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q    <= ST_IDLE;
      bit_cnt_q  <= '0;
      byte_idx_q <= '0;
      shreg_q    <= '0;
      pull_q     <= 1'b0;
    end else begin
      state_q    <= state_d;
      bit_cnt_q  <= bit_cnt_d;
      byte_idx_q <= byte_idx_d;
      shreg_q    <= shreg_d;
      pull_q     <= pull_d;
    end
  end

  assign sda_pull_o = pull_q;
  assign wr_data_o  = shreg_q;
  assign wr_idx_o   = RIDX_W'(byte_idx_q - IDX_W'(HDR_BYTES));

  // R6: the acknowledge only begins right after a bus clock fall
  assert_ack_after_fall_R6: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(pull_q) |-> $past(scl_fall_i));
  // R5: every register write is accompanied by an acknowledge
  assert_write_acked_R5: assert property (@(posedge clk) disable iff (!rst_n)
    wr_en_o |=> pull_q);
  // R9: a STOP always releases the data line
  assert_release_on_stop_R9: assert property (@(posedge clk) disable iff (!rst_n)
    stop_i |=> !pull_q);
  // R2: an ignored frame neither acknowledges nor writes
  assert_skip_silent_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (state_q == ST_SKIP) |-> (!wr_en_o && !pull_q));
endmodule

// File: rtl/cfgbus_regbank.sv
module cfgbus_regbank #(
  parameter int                       REG_BYTES = 6,
  parameter logic [8*REG_BYTES-1:0]   RST_VAL   = '0,
  parameter logic [8*REG_BYTES-1:0]   WR_MASK   = '1,
  localparam int                      RIDX_W    = (REG_BYTES > 1) ? $clog2(REG_BYTES) : 1
) (
  input  logic                     clk,
  input  logic                     rst_n,
  input  logic                     wr_en_i,
  input  logic [RIDX_W-1:0]        wr_idx_i,
  input  logic [7:0]               wr_data_i,
  output logic [8*REG_BYTES-1:0]   bank_o
);
  logic [8*REG_BYTES-1:0] bank_q;

  for (genvar g = 0; g < REG_BYTES; g++) begin : g_byte
    logic       sel;
    logic [7:0] nxt;
    assign sel = wr_en_i && (wr_idx_i == RIDX_W'(g));
    always_comb begin
      nxt = (bank_q[8*g +: 8] & ~WR_MASK[8*g +: 8]) | (wr_data_i & WR_MASK[8*g +: 8]);
    end
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)   bank_q[8*g +: 8] <= RST_VAL[8*g +: 8];
      else if (sel) bank_q[8*g +: 8] <= nxt;
    end
  end

  assign bank_o = bank_q;

  // R5: the bank only moves on a write strobe
  assert_hold_without_write_R5: assert property (@(posedge clk) disable iff (!rst_n)
    !wr_en_i |=> $stable(bank_q));
  // R10: masked-off bits always hold their reset value
  assert_reserved_fixed_R10: assert property (@(posedge clk) disable iff (!rst_n)
    (bank_q & ~WR_MASK) == (RST_VAL & ~WR_MASK));
endmodule

// File: rtl/cfgbus_rx.sv
module cfgbus_rx #(
  parameter logic [7:0]             ADDR_BYTE   = 8'hD2,
  parameter int                     HDR_BYTES   = 3,
  parameter int                     DATA_BYTES  = 8,
  parameter int                     REG_BYTES   = 6,
  parameter int                     SYNC_STAGES = 2,
  parameter int                     FS_W        = 4,
  parameter logic [8*REG_BYTES-1:0] RST_VAL     = 48'h33_00_3F_7F_0F_00,
  parameter logic [8*REG_BYTES-1:0] WR_MASK     = 48'h33_00_3F_7F_0F_7F,
  localparam int                    RIDX_W      = (REG_BYTES > 1) ? $clog2(REG_BYTES) : 1
) (
  input  logic                   clk,
  input  logic                   rst_n,
  input  logic                   scl_i,
  input  logic                   sda_i,
  input  logic [FS_W-1:0]        strap_fs_i,
  output logic                   sda_pull_o,
  output logic [1:0]             mode_o,
  output logic                   freq_src_o,
  output logic [FS_W-1:0]        freq_code_o,
  output logic [8*REG_BYTES-1:0] regs_o
);
  logic [1:0]        rst_pipe;
  logic              rst_n_int;
  logic              sda_bit, scl_rise, scl_fall, start_det, stop_det;
  logic              wr_en;
  logic [RIDX_W-1:0] wr_idx;
  logic [7:0]        wr_data;
  logic [FS_W-1:0]   reg_code;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rst_pipe <= '0;
    else        rst_pipe <= {rst_pipe[0], 1'b1};
  end
  assign rst_n_int = rst_pipe[1];

  cfgbus_sync #(.STAGES(SYNC_STAGES)) u_sync (
    .clk        (clk),
    .rst_n      (rst_n_int),
    .scl_i      (scl_i),
    .sda_i      (sda_i),
    .sda_bit_o  (sda_bit),
    .scl_rise_o (scl_rise),
    .scl_fall_o (scl_fall),
    .start_o    (start_det),
    .stop_o     (stop_det)
  );

  cfgbus_engine #(
    .ADDR_BYTE  (ADDR_BYTE),
    .HDR_BYTES  (HDR_BYTES),
    .DATA_BYTES (DATA_BYTES),
    .REG_BYTES  (REG_BYTES)
  ) u_engine (
    .clk        (clk),
    .rst_n      (rst_n_int),
    .sda_bit_i  (sda_bit),
    .scl_rise_i (scl_rise),
    .scl_fall_i (scl_fall),
    .start_i    (start_det),
    .stop_i     (stop_det),
    .sda_pull_o (sda_pull_o),
    .wr_en_o    (wr_en),
    .wr_idx_o   (wr_idx),
    .wr_data_o  (wr_data)
  );

  cfgbus_regbank #(
    .REG_BYTES (REG_BYTES),
    .RST_VAL   (RST_VAL),
    .WR_MASK   (WR_MASK)
  ) u_regbank (
    .clk       (clk),
    .rst_n     (rst_n_int),
    .wr_en_i   (wr_en),
    .wr_idx_i  (wr_idx),
    .wr_data_i (wr_data),
    .bank_o    (regs_o)
  );

  assign mode_o      = regs_o[1:0];
  assign freq_src_o  = regs_o[3];
  assign reg_code    = FS_W'({regs_o[2], regs_o[6:4]});
  assign freq_code_o = freq_src_o ? reg_code : strap_fs_i;
endmodule

// File: tb/cfgbus_rx_bench.sv
module cfgbus_rx_bench;
  localparam int Q = 10;

  logic        clk = 1'b0;
  logic        rst_n;
  logic        scl_m, sda_m;
  logic [3:0]  strap;
  logic        sda_pull;
  logic [1:0]  mode;
  logic        fsrc;
  logic [3:0]  fcode;
  logic [47:0] regs;
  wire         sda_line = sda_m & ~sda_pull;

  int n_vec  = 0;
  int n_miss = 0;
  bit done   = 1'b0;
  logic exp_ack_q[$];
  event ack_ev;

  logic [7:0] mdl [6];
  logic [7:0] rstv [6] = '{8'h00, 8'h0F, 8'h7F, 8'h3F, 8'h00, 8'h33};
  logic [7:0] mask [6] = '{8'h7F, 8'h0F, 8'h7F, 8'h3F, 8'h00, 8'h33};

  always #10 clk = ~clk;

  cfgbus_rx u_cfgbus_rx (
    .clk (clk), .rst_n (rst_n), .scl_i (scl_m), .sda_i (sda_line),
    .strap_fs_i (strap), .sda_pull_o (sda_pull), .mode_o (mode),
    .freq_src_o (fsrc), .freq_code_o (fcode), .regs_o (regs)
  );

  task automatic w(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic check(input string req, input logic [63:0] act, input logic [63:0] exp);
    n_vec++;
    if (act !== exp) begin
      n_miss++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  function automatic logic [47:0] mdl_flat();
    logic [47:0] f;
    for (int k = 0; k < 6; k++) f[8*k +: 8] = mdl[k];
    return f;
  endfunction

  function automatic void mdl_write(input int k, input logic [7:0] v);
    mdl[k] = (mdl[k] & ~mask[k]) | (v & mask[k]);
  endfunction

  task automatic bus_start();
    sda_m = 1'b1; w(Q); scl_m = 1'b1; w(Q); sda_m = 1'b0; w(Q); scl_m = 1'b0;
  endtask

  task automatic bus_stop();
    w(Q); sda_m = 1'b0; w(Q); scl_m = 1'b1; w(Q); sda_m = 1'b1; w(Q);
  endtask

  task automatic put_bit(input logic b);
    w(Q); sda_m = b; w(Q); scl_m = 1'b1; w(2*Q); scl_m = 1'b0;
  endtask

  task automatic send_bits(input logic [7:0] b, input int nbits);
    for (int i = 7; i > 7 - nbits; i--) put_bit(b[i]);
  endtask

  task automatic send_byte(input logic [7:0] b, input logic exp_ack);
    send_bits(b, 8);
    w(Q); sda_m = 1'b1; w(Q); scl_m = 1'b1; w(Q);
    exp_ack_q.push_back(exp_ack);
    -> ack_ev;
    w(Q); scl_m = 1'b0;
  endtask

  task automatic check_outputs(input string tag);
    logic [47:0] f;
    f = mdl_flat();
    check({tag, " R11 regs"}, 64'(regs), 64'(f));
    check({tag, " R7 mode"}, 64'(mode), 64'(f[1:0]));
    check({tag, " R8 src"}, 64'(fsrc), 64'(f[3]));
    check({tag, " R8 code"}, 64'(fcode), 64'(f[3] ? {f[2], f[6:4]} : strap));
  endtask

  // scoreboard monitor: pops an expected acknowledge for every ninth clock
  initial begin
    forever begin
      @(ack_ev);
      #1;
      if (exp_ack_q.size() == 0) begin
        n_vec++; n_miss++;
        $display("FAIL R6 unexpected ack slot actual=%0d expected=none", !sda_line);
      end else begin
        logic e;
        e = exp_ack_q.pop_front();
        check("R6 R2 ack", 64'(!sda_line), 64'(e));
      end
    end
  end

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      n_miss++;
      $display("FAIL watchdog actual=timeout expected=finish");
      $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_miss);
      $finish;
    end
  end

  initial begin
    rst_n = 1'b0; scl_m = 1'b1; sda_m = 1'b1; strap = 4'h9;
    for (int k = 0; k < 6; k++) mdl[k] = rstv[k];
    w(5); rst_n = 1'b1; w(6);

    // R1 reset state
    check("R1 regs", 64'(regs), 64'h33_00_3F_7F_0F_00);
    check("R1 mode", 64'(mode), 64'd0);
    check("R1 src", 64'(fsrc), 64'd0);
    check("R1 pull", 64'(sda_pull), 64'd0);
    check("R1 R8 code", 64'(fcode), 64'h9);

    // R4 R5 R10 full frame plus an extra byte
    bus_start();
    send_byte(8'hD2, 1'b1);
    send_byte(8'hA5, 1'b1);
    send_byte(8'h08, 1'b1);
    send_byte(8'h6E, 1'b1); mdl_write(0, 8'h6E);
    send_byte(8'hF5, 1'b1); mdl_write(1, 8'hF5);
    send_byte(8'h00, 1'b1); mdl_write(2, 8'h00);
    send_byte(8'hC1, 1'b1); mdl_write(3, 8'hC1);
    send_byte(8'hFF, 1'b1); mdl_write(4, 8'hFF);
    send_byte(8'hFF, 1'b1); mdl_write(5, 8'hFF);
    send_byte(8'h77, 1'b1);
    send_byte(8'h12, 1'b1);
    send_byte(8'hFF, 1'b1);
    bus_stop(); w(20);
    check_outputs("R4 R5 R10 frameA");
    check("R7 mode spread", 64'(mode), 64'd2);
    check("R8 reg code", 64'(fcode), 64'hE);

    // R3 MSB first: 0x01 sets mode 01; stop after one data byte (R9)
    bus_start();
    send_byte(8'hD2, 1'b1); send_byte(8'h00, 1'b1); send_byte(8'h00, 1'b1);
    send_byte(8'h01, 1'b1); mdl_write(0, 8'h01);
    bus_stop(); w(20);
    check_outputs("R3 msb");
    check("R3 mode test", 64'(mode), 64'd1);
    check("R8 strap code", 64'(fcode), 64'h9);

    // R2 wrong address: no acks, nothing written
    bus_start();
    send_byte(8'hD3, 1'b0);
    for (int i = 0; i < 4; i++) send_byte(8'h00, 1'b0);
    bus_stop(); w(20);
    check_outputs("R2 badaddr");

    // R8 strap follow
    strap = 4'h3; w(2);
    check("R8 strap follow", 64'(fcode), 64'h3);

    // R9 abort by STOP inside a byte
    bus_start();
    send_byte(8'hD2, 1'b1); send_byte(8'h00, 1'b1); send_byte(8'h00, 1'b1);
    send_byte(8'h03, 1'b1); mdl_write(0, 8'h03);
    send_byte(8'h0A, 1'b1); mdl_write(1, 8'h0A);
    send_bits(8'h7F, 4);
    bus_stop(); w(20);
    check_outputs("R9 stop abort");
    check("R9 byte2 kept", 64'(regs[23:16]), 64'h00);

    // R9 repeated START inside a byte, then a new frame; R10 on byte0 bit7
    bus_start();
    send_byte(8'hD2, 1'b1); send_byte(8'h00, 1'b1); send_byte(8'h00, 1'b1);
    send_byte(8'h0B, 1'b1); mdl_write(0, 8'h0B);
    send_bits(8'hFF, 5);
    bus_start();
    send_byte(8'hD2, 1'b1); send_byte(8'h11, 1'b1); send_byte(8'h22, 1'b1);
    send_byte(8'hC8, 1'b1); mdl_write(0, 8'hC8);
    send_byte(8'h03, 1'b1); mdl_write(1, 8'h03);
    bus_stop(); w(20);
    check_outputs("R9 restart");
    check("R10 byte0 bit7", 64'(regs[7:0]), 64'h48);
    check("R8 code 4", 64'(fcode), 64'h4);
    check("R6 released", 64'(sda_pull), 64'd0);

    w(10);
    check("R6 all acks seen", 64'(exp_ack_q.size()), 64'd0);
    done = 1'b1;
    $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_miss);
    $finish;
  end
endmodule